// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block holds the insert and remove bookkeeping for up to 32 slots on each of `NUM_BUS` buses and presents it to firmware through a small word-wide register window. Platform logic reports each slot event as a one-cycle pulse that carries a bus tag and a slot number. Each accepted event sets a bit in the inserted or removed bitmap of that bus and produces a one-cycle event pulse toward the interrupt logic. Firmware writes a bus number into the select register. It then reads that bus's inserted, removed and removable bitmaps and writes an eject word. The block answers with an eject strobe that carries the bus and slot numbers.

A flush sequencer runs after hard reset and again on every `flush_req` pulse. It carries out all pending removals one slot at a time, then reloads the removable bitmaps from the per-slot fixed mask. The sequencer has three states. `FL_IDLE` waits, and on `flush_req` it moves to `FL_SCAN` with the scan bus at 0. `FL_SCAN` ejects the lowest pending slot of the current bus, one per cycle. When that bus has nothing left it moves to the next bus, and after the last bus it moves to `FL_LOAD`. `FL_LOAD` copies the fixed mask into the removable bitmaps and returns to `FL_IDLE`. Hard reset enters `FL_SCAN` directly. A firmware eject write takes the eject path in its cycle, and the scan waits one cycle.

In legacy mode the select register is not used and bus 0 is always the visible bus. The window shrinks to 15 bytes, and reading the inserted bitmap no longer clears it.

Top module: `hp_slot_bank`

## Requirements
- R1: An access counts only when `be` is 4'hF, `addr[1:0]` is 0 and the word lies fully inside the window. Any other read returns 0 with no side effect, and any other write is ignored.
- R2: A plug pulse with `plug_hot`=1 and an in-range bus sets bit `plug_slot` of that bus's inserted bitmap (offset 0x00) and makes `evt_irq` high in the next cycle. A plug with `plug_hot`=0 changes nothing and raises no event.
- R3: An unplug pulse with an in-range bus sets bit `unplug_slot` of that bus's removed bitmap (offset 0x04) and makes `evt_irq` high in the next cycle.
- R4: In normal mode a read of offset 0x00 returns the inserted bitmap and clears it. In legacy mode the same read leaves the bitmap unchanged.
- R5: A read of offset 0x08 returns 0. A read of offset 0x0C returns the removable bitmap of the visible bus.
- R6: A write to offset 0x08 with nonzero data picks the lowest set bit as the slot and clears that slot's inserted and removed bits. One cycle later it pulses `ej_stb` with `ej_bus` and `ej_slot`, but only if the slot's fixed-mask bit is 0. Zero data has no effect.
- R7: Offset 0x10 stores the written value unchanged and reads it back. When the stored value is `NUM_BUS` or more, every read returns 0 and eject writes are ignored.
- R8: After reset and after `flush_req`, the pending removals of each bus are ejected one per cycle, lowest slot first and bus 0 first, with a strobe for each non-fixed slot. Each removable bitmap then becomes the inverse of its fixed mask.
- R9: In legacy mode bus 0 is visible whatever the select register holds. Only offsets 0x00 to 0x08 are decoded, so 0x0C and 0x10 read 0 and writes to them are ignored.
- R10: A slot request that arrives in the same cycle as a clearing read or an eject is kept. `evt_irq` is high for exactly one cycle per accepted request cycle.
- R11: Writes to offsets 0x00, 0x04 and 0x0C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| legacy_mode | input | 1 | Fixed bus 0, 15-byte window, inserted bitmap not cleared on read |
| flush_req | input | 1 | Pulse that starts the flush sequence |
| plug_vld | input | 1 | Plug event pulse |
| plug_hot | input | 1 | Device was added at run time |
| plug_bus | input | 8 | Bus tag of the plug event |
| plug_slot | input | 5 | Slot of the plug event |
| unplug_vld | input | 1 | Unplug request pulse |
| unplug_bus | input | 8 | Bus tag of the unplug request |
| unplug_slot | input | 5 | Slot of the unplug request |
| fixed_mask | input | NUM_BUS*32 | Per-slot not-removable flags, bus b in bits [32b+31:32b] |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Byte offset |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after `rd_en` |
| evt_irq | output | 1 | One-cycle event pulse |
| ej_stb | output | 1 | Eject strobe |
| ej_bus | output | 8 | Bus of the ejected slot |
| ej_slot | output | 5 | Ejected slot |

## Verification
Plug events are sent hot and cold to separate run-time insertions from devices that were present at power-up. Eject words with two bits set, with zero, and aimed at a fixed slot show whether the lowest-bit choice and the removability gate both hold. The flush run spreads removals over three buses in scrambled order with one fixed slot, so bus order, slot order and the strobe gate can each be told apart. Other patterns cover events that coincide with a clearing read, partial-width and misaligned accesses, an out-of-range select, and legacy mode, which exercises the second window size and the non-clearing read.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOT_N = 32;
    localparam int TAG_W  = 8;

    // word index = addr[4:2]
    localparam logic [2:0] W_INS = 3'd0;
    localparam logic [2:0] W_REM = 3'd1;
    localparam logic [2:0] W_EJ  = 3'd2;
    localparam logic [2:0] W_RMV = 3'd3;
    localparam logic [2:0] W_SEL = 3'd4;

    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_SCAN = 2'd1,
        FL_LOAD = 2'd2
    } flush_st_t;

    function automatic logic [4:0] low_idx(input logic [31:0] v);
        logic [4:0] r;
        r = 5'd0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [4:0]       addr,
    input  logic [3:0]       be,
    input  logic             legacy,
    input  logic [31:0]      sel_q,
    output logic [TAG_W-1:0] cur_bus,
    output logic             rd_ins,
    output logic             rd_rem,
    output logic             rd_rmv,
    output logic             rd_sel,
    output logic             wr_ej,
    output logic             wr_sel
);
    logic [2:0] word;
    logic       in_win;
    logic       acc_ok;
    logic       bus_ok;

    always_comb begin
        word    = addr[4:2];
        // legacy window is 15 bytes: only words fully inside it (0..2)
        in_win  = legacy ? (word <= W_EJ) : (word <= W_SEL);
        acc_ok  = in_win && (addr[1:0] == 2'b00) && (be == 4'hF);
        bus_ok  = legacy || (sel_q < 32'(NUM_BUS));
        cur_bus = legacy ? '0 : sel_q[TAG_W-1:0];

        rd_ins = rd_en && acc_ok && bus_ok && (word == W_INS);
        rd_rem = rd_en && acc_ok && bus_ok && (word == W_REM);
        rd_rmv = rd_en && acc_ok && bus_ok && (word == W_RMV);
        rd_sel = rd_en && acc_ok && bus_ok && (word == W_SEL);
        wr_ej  = wr_en && acc_ok && bus_ok && (word == W_EJ);
        wr_sel = wr_en && acc_ok && (word == W_SEL);
    end
endmodule

// File: rtl/hp_slot_store.sv
module hp_slot_store
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_BUS*32-1:0]   set_ins,
    input  logic [NUM_BUS*32-1:0]   set_rem,
    input  logic [NUM_BUS*32-1:0]   clr_ins,
    input  logic [NUM_BUS*32-1:0]   clr_rem,
    input  logic                    load_rmv,
    input  logic [NUM_BUS*32-1:0]   fixed_mask,
    output logic [NUM_BUS*32-1:0]   ins_q,
    output logic [NUM_BUS*32-1:0]   rem_q,
    output logic [NUM_BUS*32-1:0]   rmv_q
);
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        localparam int LO = g * SLOT_N;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ins_q[LO +: SLOT_N] <= '0;
                rem_q[LO +: SLOT_N] <= '0;
                rmv_q[LO +: SLOT_N] <= '0;
            end else begin
                // set wins over clear so a request is never lost
                ins_q[LO +: SLOT_N] <= (ins_q[LO +: SLOT_N] & ~clr_ins[LO +: SLOT_N])
                                     | set_ins[LO +: SLOT_N];
                rem_q[LO +: SLOT_N] <= (rem_q[LO +: SLOT_N] & ~clr_rem[LO +: SLOT_N])
                                     | set_rem[LO +: SLOT_N];
                if (load_rmv) rmv_q[LO +: SLOT_N] <= ~fixed_mask[LO +: SLOT_N];
            end
        end

        AST_INS_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_ins[LO +: SLOT_N]) |=>
            ((ins_q[LO +: SLOT_N] & $past(set_ins[LO +: SLOT_N])) == $past(set_ins[LO +: SLOT_N]))) // R10
            else $error("inserted request lost");
        AST_REM_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_rem[LO +: SLOT_N]) |=>
            ((rem_q[LO +: SLOT_N] & $past(set_rem[LO +: SLOT_N])) == $past(set_rem[LO +: SLOT_N]))) // R3
            else $error("removed request lost");
        AST_RMV_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
            load_rmv |=> (rmv_q[LO +: SLOT_N] == ~$past(fixed_mask[LO +: SLOT_N]))) // R8
            else $error("removable bitmap not loaded");
    end
endmodule

// File: rtl/hp_flush_fsm.sv
module hp_flush_fsm
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  hold,
    input  logic [NUM_BUS*32-1:0] rem_flat,
    output logic                  step_vld,
    output logic [TAG_W-1:0]      step_bus,
    output logic [4:0]            step_slot,
    output logic                  load_rmv
);
    localparam int BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
    localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

    flush_st_t        st_q, st_d;
    logic [BUS_W-1:0] bus_q, bus_d;
    logic [31:0]      cur;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FL_SCAN;
            bus_q <= '0;
        end else begin
            st_q  <= st_d;
            bus_q <= bus_d;
        end
    end

    // next state and outputs
    always_comb begin
        cur       = rem_flat[SLOT_N*int'(bus_q) +: SLOT_N];
        st_d      = st_q;
        bus_d     = bus_q;
        step_vld  = 1'b0;
        load_rmv  = 1'b0;
        step_bus  = TAG_W'(bus_q);
        step_slot = low_idx(cur);
        unique case (st_q)
            FL_IDLE: begin
                if (start) begin
                    st_d  = FL_SCAN;
                    bus_d = '0;
                end
            end
            FL_SCAN: begin
                if (!hold) begin
                    if (cur != 32'd0) begin
                        step_vld = 1'b1;
                    end else if (bus_q == LAST_BUS) begin
                        st_d = FL_LOAD;
                    end else begin
                        bus_d = bus_q + 1'b1;
                    end
                end
            end
            FL_LOAD: begin
                load_rmv = 1'b1;
                st_d     = FL_IDLE;
            end
            default: st_d = FL_IDLE;
        endcase
    end

    AST_FLUSH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        step_vld |-> (cur[step_slot] && ((cur & ((32'd1 << step_slot) - 32'd1)) == 32'd0))) // R8
        else $error("flush did not pick lowest slot");
    AST_LOAD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_LOAD) |=> (st_q == FL_IDLE)) // R8
        else $error("load state not followed by idle");
    AST_SCAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && !start) |=> !rem_flat[SLOT_N*int'($past(bus_q)) + int'($past(step_slot))]) // R8
        else $error("flushed slot still pending");
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  legacy_mode,
    input  logic                  flush_req,
    input  logic                  plug_vld,
    input  logic                  plug_hot,
    input  logic [7:0]            plug_bus,
    input  logic [4:0]            plug_slot,
    input  logic                  unplug_vld,
    input  logic [7:0]            unplug_bus,
    input  logic [4:0]            unplug_slot,
    input  logic [NUM_BUS*32-1:0] fixed_mask,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [4:0]            addr,
    input  logic [3:0]            be,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic                  evt_irq,
    output logic                  ej_stb,
    output logic [7:0]            ej_bus,
    output logic [4:0]            ej_slot
);
    localparam int BANK_W = NUM_BUS * SLOT_N;

    logic [31:0]       sel_q;
    logic [TAG_W-1:0]  cur_bus;
    logic              rd_ins, rd_rem, rd_rmv, rd_sel, wr_ej, wr_sel;
    logic [BANK_W-1:0] set_ins, set_rem, clr_ins, clr_rem;
    logic [BANK_W-1:0] ins_q, rem_q, rmv_q;
    logic              load_rmv;
    logic              step_vld;
    logic [TAG_W-1:0]  step_bus;
    logic [4:0]        step_slot;
    logic              plug_acc, unplug_acc;
    logic              ej_req;
    logic [4:0]        wr_slot;
    logic [31:0]       rdata_d;
    logic              ej_fire_d;
    logic [TAG_W-1:0]  ej_bus_d;
    logic [4:0]        ej_slot_d;

    hp_reg_decode #(.NUM_BUS(NUM_BUS)) u_dec (
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .be      (be),
        .legacy  (legacy_mode),
        .sel_q   (sel_q),
        .cur_bus (cur_bus),
        .rd_ins  (rd_ins),
        .rd_rem  (rd_rem),
        .rd_rmv  (rd_rmv),
        .rd_sel  (rd_sel),
        .wr_ej   (wr_ej),
        .wr_sel  (wr_sel)
    );

    hp_flush_fsm #(.NUM_BUS(NUM_BUS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (flush_req),
        .hold      (wr_ej),
        .rem_flat  (rem_q),
        .step_vld  (step_vld),
        .step_bus  (step_bus),
        .step_slot (step_slot),
        .load_rmv  (load_rmv)
    );

    hp_slot_store #(.NUM_BUS(NUM_BUS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ins    (set_ins),
        .set_rem    (set_rem),
        .clr_ins    (clr_ins),
        .clr_rem    (clr_rem),
        .load_rmv   (load_rmv),
        .fixed_mask (fixed_mask),
        .ins_q      (ins_q),
        .rem_q      (rem_q),
        .rmv_q      (rmv_q)
    );

    always_comb begin
        plug_acc   = plug_vld && plug_hot && (plug_bus < TAG_W'(NUM_BUS));
        unplug_acc = unplug_vld && (unplug_bus < TAG_W'(NUM_BUS));
        wr_slot    = low_idx(wdata);
        ej_req     = wr_ej && (wdata != 32'd0);
    end

    // set and clear vectors for the bitmap store
    always_comb begin
        set_ins = '0;
        set_rem = '0;
        clr_ins = '0;
        clr_rem = '0;
        if (plug_acc)
            set_ins[SLOT_N*int'(plug_bus) + int'(plug_slot)] = 1'b1;
        if (unplug_acc)
            set_rem[SLOT_N*int'(unplug_bus) + int'(unplug_slot)] = 1'b1;
        if (rd_ins && !legacy_mode)
            clr_ins[SLOT_N*int'(cur_bus) +: SLOT_N] = '1;
        if (ej_req) begin
            clr_ins[SLOT_N*int'(cur_bus) + int'(wr_slot)] = 1'b1;
            clr_rem[SLOT_N*int'(cur_bus) + int'(wr_slot)] = 1'b1;
        end
        if (step_vld) begin
            clr_ins[SLOT_N*int'(step_bus) + int'(step_slot)] = 1'b1;
            clr_rem[SLOT_N*int'(step_bus) + int'(step_slot)] = 1'b1;
        end
    end

    // read mux
    always_comb begin
        rdata_d = 32'd0;
        if (rd_ins) rdata_d = ins_q[SLOT_N*int'(cur_bus) +: SLOT_N];
        if (rd_rem) rdata_d = rem_q[SLOT_N*int'(cur_bus) +: SLOT_N];
        if (rd_rmv) rdata_d = rmv_q[SLOT_N*int'(cur_bus) +: SLOT_N];
        if (rd_sel) rdata_d = sel_q;
    end

    // eject source: firmware write first, flush step otherwise
    always_comb begin
        ej_fire_d = 1'b0;
        ej_bus_d  = step_bus;
        ej_slot_d = step_slot;
        if (ej_req) begin
            ej_bus_d  = cur_bus;
            ej_slot_d = wr_slot;
            ej_fire_d = !fixed_mask[SLOT_N*int'(cur_bus) + int'(wr_slot)];
        end else if (step_vld) begin
            ej_fire_d = !fixed_mask[SLOT_N*int'(step_bus) + int'(step_slot)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 32'd0;
            rdata   <= 32'd0;
            evt_irq <= 1'b0;
            ej_stb  <= 1'b0;
            ej_bus  <= '0;
            ej_slot <= '0;
        end else begin
            if (wr_sel) sel_q <= wdata;
            if (rd_en)  rdata <= rdata_d;
            evt_irq <= plug_acc || unplug_acc;
            ej_stb  <= ej_fire_d;
            if (ej_fire_d) begin
                ej_bus  <= ej_bus_d;
                ej_slot <= ej_slot_d;
            end
        end
    end

    AST_HOT_PLUG_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_vld && plug_hot && plug_bus < 8'(NUM_BUS)) |=> evt_irq) // R2
        else $error("hot plug without event");
    AST_QUIET_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (!(plug_vld && plug_hot) && !unplug_vld) |=> !evt_irq) // R10
        else $error("event without request");
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !legacy_mode && sel_q >= 32'(NUM_BUS)) |=> (rdata == 32'd0)) // R7
        else $error("out-of-range select read nonzero");
    AST_FEATURES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'h08) |=> (rdata == 32'd0)) // R5
        else $error("features read nonzero");
    AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && be != 4'hF) |=> (rdata == 32'd0)) // R1
        else $error("partial read returned data");
endmodule

// File: tb/hp_slot_bank_test.sv
`timescale 1ns/1ps
module hp_slot_bank_test;
    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              legacy_mode = 1'b0;
    logic              flush_req = 1'b0;
    logic              plug_vld = 1'b0, plug_hot = 1'b0;
    logic [7:0]        plug_bus = '0;
    logic [4:0]        plug_slot = '0;
    logic              unplug_vld = 1'b0;
    logic [7:0]        unplug_bus = '0;
    logic [4:0]        unplug_slot = '0;
    logic [NB*32-1:0]  fixed_mask = '0;
    logic              rd_en = 1'b0, wr_en = 1'b0;
    logic [4:0]        addr = '0;
    logic [3:0]        be = 4'hF;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              evt_irq, ej_stb;
    logic [7:0]        ej_bus;
    logic [4:0]        ej_slot;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] rv;
    logic        s_stb, s_evt;
    logic [7:0]  s_bus;
    logic [4:0]  s_slot;

    always #10 clk = ~clk;

    hp_slot_bank #(.NUM_BUS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .flush_req(flush_req),
        .plug_vld(plug_vld), .plug_hot(plug_hot), .plug_bus(plug_bus), .plug_slot(plug_slot),
        .unplug_vld(unplug_vld), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
        .fixed_mask(fixed_mask), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be),
        .wdata(wdata), .rdata(rdata), .evt_irq(evt_irq), .ej_stb(ej_stb),
        .ej_bus(ej_bus), .ej_slot(ej_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic rd(input logic [4:0] a, input logic [3:0] b = 4'hF);
        @(negedge clk); rd_en = 1'b1; addr = a; be = b;
        @(negedge clk); rd_en = 1'b0; be = 4'hF; rv = rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk); wr_en = 1'b0; be = 4'hF;
        s_stb = ej_stb; s_bus = ej_bus; s_slot = ej_slot;
    endtask

    task automatic plug(input int bus, input int slot, input bit hot);
        @(negedge clk); plug_vld = 1'b1; plug_hot = hot; plug_bus = 8'(bus); plug_slot = 5'(slot);
        @(negedge clk); plug_vld = 1'b0; s_evt = evt_irq;
    endtask

    task automatic unplug(input int bus, input int slot);
        @(negedge clk); unplug_vld = 1'b1; unplug_bus = 8'(bus); unplug_slot = 5'(slot);
        @(negedge clk); unplug_vld = 1'b0; s_evt = evt_irq;
    endtask

    task automatic t_reset();
        chk_eq("R8 rdata at reset", rdata, 0);
        chk_eq("R2 evt at reset", 32'(evt_irq), 0);
        chk_eq("R8 ej_stb idle after reset", 32'(ej_stb), 0);
        rd(5'h0C); chk_eq("R8 removable bus0 after reset", rv, 32'hFFFF_FFFF);
        wr(5'h10, 1);
        rd(5'h0C); chk_eq("R8 removable bus1 minus fixed slot", rv, 32'hFFFF_FDFF);
        wr(5'h10, 0);
    endtask

    task automatic t_plug();
        plug(0, 5, 1); chk_eq("R2 hot plug event", 32'(s_evt), 1);
        @(negedge clk); chk_eq("R10 event one cycle", 32'(evt_irq), 0);
        plug(0, 6, 0); chk_eq("R2 cold plug no event", 32'(s_evt), 0);
        rd(5'h00); chk_eq("R2 inserted bitmap", rv, 32'h20);
        rd(5'h00); chk_eq("R4 inserted cleared by read", rv, 0);
    endtask

    task automatic t_merge();
        plug(0, 7, 1);
        @(negedge clk); rd_en = 1'b1; addr = 5'h00;
        plug_vld = 1'b1; plug_hot = 1'b1; plug_bus = 8'd0; plug_slot = 5'd8;
        @(negedge clk); rd_en = 1'b0; plug_vld = 1'b0; rv = rdata;
        chk_eq("R10 read returns old bitmap", rv, 32'h80);
        rd(5'h00); chk_eq("R10 plug during clearing read kept", rv, 32'h100);
    endtask

    task automatic t_unplug_eject();
        unplug(0, 5); chk_eq("R3 unplug event", 32'(s_evt), 1);
        unplug(0, 12);
        rd(5'h04); chk_eq("R3 removed bitmap", rv, 32'h1020);
        plug(0, 5, 1);
        wr(5'h08, 32'h1020);
        chk_eq("R6 eject strobe", 32'(s_stb), 1);
        chk_eq("R6 eject bus", 32'(s_bus), 0);
        chk_eq("R6 eject lowest slot", 32'(s_slot), 5);
        rd(5'h04); chk_eq("R6 removed bit cleared", rv, 32'h1000);
        rd(5'h00); chk_eq("R6 inserted bit cleared", rv, 0);
        wr(5'h08, 0); chk_eq("R6 zero eject no strobe", 32'(s_stb), 0);
        rd(5'h04); chk_eq("R6 zero eject no change", rv, 32'h1000);
        wr(5'h08, 32'h1000); chk_eq("R6 second eject slot", 32'(s_slot), 12);
    endtask

    task automatic t_fixed_access();
        wr(5'h10, 1);
        unplug(1, 9);
        wr(5'h08, 32'h200); chk_eq("R6 fixed slot no strobe", 32'(s_stb), 0);
        rd(5'h04); chk_eq("R6 fixed slot bit cleared", rv, 0);
        rd(5'h08); chk_eq("R5 features read zero", rv, 0);
        rd(5'h10); chk_eq("R7 select read back", rv, 1);
        unplug(1, 4);
        rd(5'h04, 4'h3); chk_eq("R1 partial read zero", rv, 0);
        rd(5'h06); chk_eq("R1 misaligned read zero", rv, 0);
        wr(5'h04, 32'hFFFF);
        rd(5'h04); chk_eq("R11 write to removed ignored", rv, 32'h10);
        wr(5'h0C, 0);
        rd(5'h0C); chk_eq("R11 write to removable ignored", rv, 32'hFFFF_FDFF);
        wr(5'h08, 32'h10, 4'h3); chk_eq("R1 partial eject ignored", 32'(s_stb), 0);
        rd(5'h04); chk_eq("R1 partial eject left bit", rv, 32'h10);
        wr(5'h08, 32'h10); chk_eq("R6 eject bus1", 32'(s_bus), 1);
    endtask

    task automatic t_oor();
        unplug(3, 1);
        wr(5'h10, 7);
        rd(5'h04); chk_eq("R7 oor removed reads zero", rv, 0);
        rd(5'h10); chk_eq("R7 oor select reads zero", rv, 0);
        rd(5'h0C); chk_eq("R7 oor removable reads zero", rv, 0);
        wr(5'h08, 2); chk_eq("R7 oor eject ignored", 32'(s_stb), 0);
        wr(5'h10, 3);
        rd(5'h04); chk_eq("R7 bus3 still pending", rv, 2);
    endtask

    task automatic t_legacy();
        legacy_mode = 1'b1;
        plug(0, 4, 1);
        rd(5'h00); chk_eq("R9 legacy shows bus0", rv, 32'h10);
        rd(5'h00); chk_eq("R4 legacy read keeps bitmap", rv, 32'h10);
        rd(5'h10); chk_eq("R9 legacy select outside window", rv, 0);
        rd(5'h0C); chk_eq("R9 legacy removable outside window", rv, 0);
        wr(5'h10, 2);
        legacy_mode = 1'b0;
        rd(5'h10); chk_eq("R9 legacy select write ignored", rv, 3);
        wr(5'h10, 0);
        rd(5'h00); chk_eq("R4 normal read after legacy", rv, 32'h10);
        rd(5'h00); chk_eq("R4 cleared after normal read", rv, 0);
    endtask

    task automatic t_flush();
        logic [7:0] eb [8];
        logic [4:0] es [8];
        int n = 0;
        unplug(1, 9); unplug(2, 7); unplug(1, 3); unplug(2, 2);
        fixed_mask[64] = 1'b1;
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (ej_stb && n < 8) begin eb[n] = ej_bus; es[n] = ej_slot; n++; end
            @(negedge clk);
        end
        chk_eq("R8 flush strobe count", 32'(n), 4);
        if (n == 4) begin
            chk_eq("R8 flush 1st", {24'(eb[0]), 8'(es[0])}, {24'd1, 8'd3});
            chk_eq("R8 flush 2nd", {24'(eb[1]), 8'(es[1])}, {24'd2, 8'd2});
            chk_eq("R8 flush 3rd", {24'(eb[2]), 8'(es[2])}, {24'd2, 8'd7});
            chk_eq("R8 flush 4th", {24'(eb[3]), 8'(es[3])}, {24'd3, 8'd1});
        end
        for (int b = 1; b < 4; b++) begin
            wr(5'h10, 32'(b));
            rd(5'h04); chk_eq("R8 removed empty after flush", rv, 0);
        end
        wr(5'h10, 2);
        rd(5'h0C); chk_eq("R8 removable reload bus2", rv, 32'hFFFF_FFFE);
        wr(5'h10, 1);
        rd(5'h0C); chk_eq("R8 removable reload bus1", rv, 32'hFFFF_FDFF);
    endtask

    initial begin
        fixed_mask[32 + 9] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_plug();
        t_merge();
        t_unplug_eject();
        t_fixed_access();
        t_oor();
        t_legacy();
        t_flush();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule